// File: doc/BRIEF.md
# Latchup Power Domain Controller

This block manages several switched power domains, each fed through its own latchup protection switch. Each switch reports a latchup by pulling a status line low. The controller then keeps that domain's release line low for a programmable protection interval. When the interval ends it raises the release line for a programmable number of clocks, so the switch reconnects the supply. A separate power-off bit per domain, set by a host through a small write port, holds a domain switched off for as long as the host wants.

One free-running counter counts from zero up to a programmed limit and then wraps. It times the protection interval for every domain. When a domain detects a latchup, it records the counter value. Protection ends when the counter comes back around to that value, one full counter period later. Each domain has its own state machine, so latchups in several domains are timed at the same time and independently of each other. Every domain reports a two-bit status: active, protected or off.

Top module: `latchup_pwr_ctrl`

## Requirements
- R1: After reset, all release outputs and all power-off outputs are low, and every domain status reads 00 (active). The reset values are a counter limit of 15 and a release width of 2.
- R2: Each latchup input passes through two synchronizing flops. A falling edge of the synchronized value starts protection. Status reads 01 (protected) from the third rising clock edge after the input falls, and the release output stays low.
- R3: With counter limit C, the interval is L = C+1 clocks. The release output goes high on the (3+L)-th rising edge after the latchup input falls.
- R4: The release output stays high for W clocks, where W is the programmed width; a width of 0 acts as 1. After the pulse ends, status reads 00.
- R5: Further falling edges on a domain's latchup input during its protection or release phase neither restart nor extend that phase.
- R6: Domains run independently. Latchups that overlap in time in different domains are each timed from their own detection.
- R7: Writing address 0 loads the power-off bits from data bits [N-1:0]. Each bit shows on the power-off outputs one clock after the write. A domain whose bit is high reads status 10 (off), keeps its release output low and ignores latchups. When the bit is cleared, the domain returns to status 00.
- R8: Suppose the counter limit is lowered below the value a protected domain recorded. That protection then ends at the next point where the counter reads zero, so the release pulse starts within C_new+5 clocks after the write edge.
- R9: Address 1 loads the counter limit and address 2 loads the release width. A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 power-off bits, 1 counter limit, 2 release width |
| cfg_wdata | input | DATA_W | Write data |
| tstart_n | input | N_DOM | Latchup-detected input per domain, low means latchup |
| tstop | output | N_DOM | Release line per domain, low during protection, high pulse restores power |
| poff | output | N_DOM | Long-term power-off per domain |
| dom_status | output | 2*N_DOM | Two bits per domain: 00 active, 01 protected, 10 off |

## Verification
Several properties are checked on every cycle. A detected falling edge always enters protection, and protection is held until the counter comes back around. A set power-off bit forces the off state. A release pulse can only follow protection. The counter never passes a stable limit. A write to the unused address leaves all registers untouched. Only the bench scenarios can show the exact clock count from a latchup to the release pulse. They also show the pulse width, including the zero-width case, and that overlapping latchups in three domains are timed separately. Finally, they show that repeated edges during protection and latchups in a powered-off domain leave no trace, and that lowering the limit mid-interval still ends protection in bounded time.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

    typedef enum logic [1:0] {
        DOM_ACTIVE  = 2'b00,
        DOM_PROT    = 2'b01,
        DOM_OFF     = 2'b10,
        DOM_RELEASE = 2'b11
    } dom_state_e;

    localparam logic [1:0] ADDR_POFF  = 2'd0;
    localparam logic [1:0] ADDR_LIMIT = 2'd1;
    localparam logic [1:0] ADDR_WIDTH = 2'd2;

    function automatic logic [1:0] status_code(dom_state_e s);
        return (s == DOM_RELEASE) ? DOM_PROT : s;
    endfunction

endpackage

// File: rtl/lpc_regs.sv
module lpc_regs
    import lpc_pkg::*;
#(
    parameter int N_DOM     = 4,
    parameter int CNT_W     = 8,
    parameter int PW_W      = 4,
    parameter int DATA_W    = 8,
    parameter int LIMIT_RST = 15,
    parameter int WIDTH_RST = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [N_DOM-1:0]  poff_o,
    output logic [CNT_W-1:0]  limit_o,
    output logic [PW_W-1:0]   width_o
);

    typedef struct packed {
        logic [N_DOM-1:0] poff;
        logic [CNT_W-1:0] limit;
        logic [PW_W-1:0]  width;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (cfg_we) begin
            case (cfg_addr)
                ADDR_POFF:  r_d.poff  = cfg_wdata[N_DOM-1:0];
                ADDR_LIMIT: r_d.limit = cfg_wdata[CNT_W-1:0];
                ADDR_WIDTH: r_d.width = cfg_wdata[PW_W-1:0];
                default:    r_d = r_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.poff  <= '0;
            r_q.limit <= CNT_W'(LIMIT_RST);
            r_q.width <= PW_W'(WIDTH_RST);
        end else begin
            r_q <= r_d;
        end
    end

    assign poff_o  = r_q.poff;
    assign limit_o = r_q.limit;
    assign width_o = r_q.width;

    // R9: the unused address leaves every register untouched
    a_r9_spare_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == 2'd3) |=> ($stable(poff_o) && $stable(limit_o) && $stable(width_o)));

endmodule

// File: rtl/lpc_timebase.sv
module lpc_timebase #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] limit_i,
    output logic [CNT_W-1:0] cnt_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tb_t;

    tb_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (t_q.cnt >= limit_i) begin
            t_d.cnt = '0;
        end else begin
            t_d.cnt = t_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign cnt_o = t_q.cnt;

    // R3: with a steady limit the counter stays in range, so every value recurs each period
    a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(limit_i) |-> (cnt_o <= limit_i));

endmodule

// File: rtl/lpc_domain.sv
module lpc_domain
    import lpc_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int PW_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tstart_n_i,
    input  logic             poff_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] limit_i,
    input  logic [PW_W-1:0]  width_i,
    output logic             tstop_o,
    output logic [1:0]       status_o
);

    typedef struct packed {
        logic [2:0]       sync;
        dom_state_e       state;
        logic [CNT_W-1:0] saved;
        logic [PW_W-1:0]  pcnt;
    } dom_t;

    dom_t d_d, d_q;

    logic            fall;
    logic            hit;
    logic [PW_W-1:0] wmax;

    always_comb begin
        fall = d_q.sync[2] & ~d_q.sync[1];
        hit  = (cnt_i == d_q.saved) || ((cnt_i == '0) && (d_q.saved > limit_i));
        wmax = (width_i == '0) ? PW_W'(1) : width_i;

        d_d      = d_q;
        d_d.sync = {d_q.sync[1:0], tstart_n_i};

        if (poff_i) begin
            d_d.state = DOM_OFF;
            d_d.pcnt  = '0;
        end else begin
            case (d_q.state)
                DOM_ACTIVE: begin
                    if (fall) begin
                        d_d.state = DOM_PROT;
                        d_d.saved = cnt_i;
                    end
                end
                DOM_PROT: begin
                    if (hit) begin
                        d_d.state = DOM_RELEASE;
                        d_d.pcnt  = PW_W'(1);
                    end
                end
                DOM_RELEASE: begin
                    if (d_q.pcnt >= wmax) begin
                        d_d.state = DOM_ACTIVE;
                        d_d.pcnt  = '0;
                    end else begin
                        d_d.pcnt = d_q.pcnt + 1'b1;
                    end
                end
                default: begin
                    d_d.state = DOM_ACTIVE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_q.sync  <= '1;
            d_q.state <= DOM_ACTIVE;
            d_q.saved <= '0;
            d_q.pcnt  <= '0;
        end else begin
            d_q <= d_d;
        end
    end

    assign tstop_o  = (d_q.state == DOM_RELEASE);
    assign status_o = status_code(d_q.state);

    // R2: a synchronized falling edge in an active, powered domain starts protection
    a_r2_enter_prot: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && d_q.state == DOM_ACTIVE && !poff_i) |=> (status_o == 2'b01 && !tstop_o));

    // R5: protection holds until the counter match, whatever the latchup input does
    a_r5_hold_prot: assert property (@(posedge clk) disable iff (!rst_n)
        (d_q.state == DOM_PROT && !hit && !poff_i) |=> (d_q.state == DOM_PROT));

    // R3: a release pulse can only begin from the protected state
    a_r3_release_src: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tstop_o) |-> ($past(d_q.state) == DOM_PROT));

    // R4: with a steady width the pulse counter never passes the effective width
    a_r4_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (d_q.state == DOM_RELEASE && $stable(width_i)) |-> (d_q.pcnt <= wmax));

    // R7: a power-off bit forces the off state with the release line low
    a_r7_off_forced: assert property (@(posedge clk) disable iff (!rst_n)
        poff_i |=> (status_o == 2'b10 && !tstop_o));

endmodule

// File: rtl/latchup_pwr_ctrl.sv
module latchup_pwr_ctrl
    import lpc_pkg::*;
#(
    parameter int N_DOM     = 4,
    parameter int CNT_W     = 8,
    parameter int PW_W      = 4,
    parameter int LIMIT_RST = 15,
    parameter int WIDTH_RST = 2,
    localparam int DATA_W   = (N_DOM > CNT_W) ? ((N_DOM > PW_W) ? N_DOM : PW_W)
                                              : ((CNT_W > PW_W) ? CNT_W : PW_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_addr,
    input  logic [DATA_W-1:0]  cfg_wdata,
    input  logic [N_DOM-1:0]   tstart_n,
    output logic [N_DOM-1:0]   tstop,
    output logic [N_DOM-1:0]   poff,
    output logic [2*N_DOM-1:0] dom_status
);

    logic [N_DOM-1:0] poff_w;
    logic [CNT_W-1:0] limit_w;
    logic [PW_W-1:0]  width_w;
    logic [CNT_W-1:0] cnt_w;

    lpc_regs #(
        .N_DOM(N_DOM), .CNT_W(CNT_W), .PW_W(PW_W), .DATA_W(DATA_W),
        .LIMIT_RST(LIMIT_RST), .WIDTH_RST(WIDTH_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .poff_o(poff_w), .limit_o(limit_w), .width_o(width_w)
    );

    lpc_timebase #(.CNT_W(CNT_W)) u_timebase (
        .clk(clk), .rst_n(rst_n), .limit_i(limit_w), .cnt_o(cnt_w)
    );

    for (genvar g = 0; g < N_DOM; g++) begin : g_dom
        lpc_domain #(.CNT_W(CNT_W), .PW_W(PW_W)) u_dom (
            .clk(clk), .rst_n(rst_n),
            .tstart_n_i(tstart_n[g]), .poff_i(poff_w[g]),
            .cnt_i(cnt_w), .limit_i(limit_w), .width_i(width_w),
            .tstop_o(tstop[g]), .status_o(dom_status[2*g +: 2])
        );
    end

    assign poff = poff_w;

endmodule

// File: tb/test_latchup_pwr_ctrl.sv
module test_latchup_pwr_ctrl;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_we = 1'b0;
    logic [1:0]   cfg_addr = 2'd0;
    logic [7:0]   cfg_wdata = 8'd0;
    logic [N-1:0] tstart_n = '1;
    logic [N-1:0] tstop;
    logic [N-1:0] poff;
    logic [2*N-1:0] dom_status;

    latchup_pwr_ctrl i_latchup_pwr_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .tstart_n(tstart_n), .tstop(tstop),
        .poff(poff), .dom_status(dom_status)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int failures = 0;
    int cur_limit = 15;
    int cur_width = 2;

    typedef struct {
        int dom;
        int lo;
        int hi;
        int width;
    } exp_t;
    exp_t sbq[$];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic int st(input int d);
        return int'(dom_status[2*d +: 2]);
    endfunction

    task automatic cfg_write(input logic [1:0] a, input int v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = 8'(v);
        @(negedge clk);
        cfg_we = 1'b0;
        if (a == 2'd1) cur_limit = v;
        if (a == 2'd2) cur_width = v;
    endtask

    // drive one latchup; push the expected release pulse
    task automatic latch(input int d);
        int n;
        @(negedge clk);
        n = cyc;
        tstart_n[d] = 1'b0;
        sbq.push_back('{d, n + 4 + cur_limit, n + 4 + cur_limit,
                        (cur_width == 0) ? 1 : cur_width});
        repeat (3) @(negedge clk);
        chk(st(d) == 1 && tstop[d] == 1'b0, "R2 status protected", st(d), 1);
        tstart_n[d] = 1'b1;
    endtask

    task automatic wait_idle();
        while (sbq.size() != 0) @(negedge clk);
        repeat (8) @(negedge clk);
    endtask

    // monitor: pops the expected pulse on each rise, checks its width on each fall
    int hi_cnt[N];
    int exp_w[N];
    logic [N-1:0] prev_tstop = '0;
    initial begin
        for (int d = 0; d < N; d++) begin hi_cnt[d] = 0; exp_w[d] = 0; end
        forever begin
            @(negedge clk);
            if (rst_n) begin
                for (int d = 0; d < N; d++) begin
                    if (tstop[d] && !prev_tstop[d]) begin
                        if (sbq.size() == 0) begin
                            chk(1'b0, "R7 unexpected release pulse", d, -1);
                            exp_w[d] = 1;
                        end else begin
                            exp_t e;
                            e = sbq.pop_front();
                            chk(e.dom == d, "R6 pulse domain", d, e.dom);
                            chk(cyc >= e.lo && cyc <= e.hi, "R3 pulse start cycle", cyc, e.hi);
                            exp_w[d] = e.width;
                        end
                        hi_cnt[d] = 1;
                    end else if (tstop[d]) begin
                        hi_cnt[d]++;
                    end else if (prev_tstop[d]) begin
                        chk(hi_cnt[d] == exp_w[d], "R4 pulse width", hi_cnt[d], exp_w[d]);
                        chk(st(d) == 0, "R4 status active after pulse", st(d), 0);
                    end
                end
                prev_tstop = tstop;
            end
        end
    end

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog expired", cyc, 20000);
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tstop == '0, "R1 reset tstop", int'(tstop), 0);
        chk(poff == '0, "R1 reset poff", int'(poff), 0);
        chk(dom_status == '0, "R1 reset status", int'(dom_status), 0);

        // R3 and R4 with reset settings
        latch(0);
        wait_idle();

        // R9: limit and width registers
        cfg_write(2'd1, 5);
        cfg_write(2'd2, 4);
        latch(1);
        wait_idle();

        // R4: zero width acts as one, smallest limit
        cfg_write(2'd2, 0);
        cfg_write(2'd1, 0);
        latch(2);
        wait_idle();

        // R6: overlapping latchups in three domains
        cfg_write(2'd1, 9);
        cfg_write(2'd2, 3);
        fork
            latch(0);
            begin repeat (2) @(negedge clk); latch(2); end
            begin repeat (4) @(negedge clk); latch(3); end
        join
        wait_idle();

        // R5: repeated falling edges during protection
        begin
            int n;
            @(negedge clk);
            n = cyc;
            tstart_n[3] = 1'b0;
            sbq.push_back('{3, n + 4 + cur_limit, n + 4 + cur_limit, cur_width});
            repeat (2) @(negedge clk); tstart_n[3] = 1'b1;
            repeat (2) @(negedge clk); tstart_n[3] = 1'b0;
            repeat (2) @(negedge clk); tstart_n[3] = 1'b1;
            chk(st(3) == 1, "R5 still protected", st(3), 1);
        end
        wait_idle();

        // R7: power-off bit holds a domain off and masks latchups
        cfg_write(2'd0, 2);
        chk(poff == 4'b0010, "R7 poff output", int'(poff), 2);
        @(negedge clk);
        chk(st(1) == 2, "R7 status off", st(1), 2);
        chk(st(0) == 0, "R7 other domain active", st(0), 0);
        tstart_n[1] = 1'b0;
        repeat (25) @(negedge clk);
        chk(st(1) == 2 && tstop[1] == 1'b0, "R7 latchup ignored while off", st(1), 2);
        tstart_n[1] = 1'b1;
        repeat (4) @(negedge clk);
        cfg_write(2'd0, 0);
        @(negedge clk);
        chk(st(1) == 0 && poff == '0, "R7 back to active", st(1), 0);
        latch(1);
        wait_idle();

        // R9: spare address changes nothing
        cfg_write(2'd3, 0);
        latch(0);
        wait_idle();

        // R8: limit lowered during protection
        cfg_write(2'd1, 59);
        @(negedge clk);
        tstart_n[2] = 1'b0;
        repeat (3) @(negedge clk);
        chk(st(2) == 1, "R8 protected", st(2), 1);
        tstart_n[2] = 1'b1;
        repeat (7) @(negedge clk);
        begin
            int w;
            w = cyc;
            sbq.push_back('{2, w + 1, w + 8, cur_width});
        end
        cfg_write(2'd1, 3);
        wait_idle();

        report();
    end

endmodule